// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the memory-mapped register front end of a simple asynchronous serial port. A host reaches it over a byte-wide synchronous bus with a word address, a write strobe, a read strobe, write data and combinational read data. It holds the line status and handshake status registers, the control word, the receive and transmit command words and a 16-bit baud divisor. It passes configuration to a separate serial engine and takes single-cycle event pulses back from that engine.

Each status register is reached at two addresses. Writing ones at the first address clears those bits. Writing ones at the second address forces those bits on. Receive and transmit data share one address: a read returns the last received byte and a write loads the transmit holding byte. From the command words and the status bits the block derives an interrupt line and two DMA request lines. Bit shifting, FIFOs and the DMA controller are outside this block.

Top module: `uart_regfile`

## Requirements
- R1: After reset the line status reads 0x06, so transmit-holding-empty (0x04) and transmit-shift-empty (0x02) are set and all other bits are 0. The handshake status, control, both command words and both divisor bytes read 0, and irq, dma_req2 and dma_req3 are low.
- R2: Every value written to control (offset 0x18), receive command (0x1C), transmit command (0x20), divisor high (0x10) or divisor low (0x14) reads back unchanged. It also appears on cfg_ctrl, cfg_rx_cmd, cfg_tx_cmd or cfg_divisor from the cycle after the write.
- R3: Line status reads at 0x00 and at 0x04, and handshake status reads at 0x08 and at 0x0C. A write at 0x00 or 0x08 clears the bits that are 1 in the data. A write at 0x04 or 0x0C sets them. Line status bit 0 and handshake bits 5..0 always read 0. An engine event in the same cycle as a clearing write takes priority over that write.
- R4: An ev_rx_valid pulse stores ev_rx_byte and sets data-ready (0x80). A read at offset 0x24 returns the stored byte and clears data-ready, unless a new byte arrives in the same cycle.
- R5: An ev_rx_valid pulse that arrives while data-ready is set, in a cycle with no data read, sets overrun (0x20).
- R6: The ev_frame_err, ev_parity_err and ev_break pulses set 0x40, 0x10 and 0x08 respectively.
- R7: A write at offset 0x24 places the byte on tx_data, pulses tx_load high for one cycle and clears 0x04. An ev_tx_taken pulse sets 0x04 and clears 0x02. An ev_tx_done pulse sets 0x02.
- R8: A change of dsr_in from its previous-cycle value sets handshake bit 0x80. A change of cts_in sets bit 0x40. Both bits stay set while the lines are steady and are cleared only by a write.
- R9: Command bits 6:5 select the request route: 00 none, 01 irq, 10 dma_req2, 11 dma_req3. The receive request is active when receive command bit 0x80 and data-ready are both set.
- R10: The transmit request is active when transmit command bits 0x80 and 0x10 and transmit-holding-empty are all set. It follows the route in transmit command bits 6:5, with the same encoding as R9.
- R11: irq is also raised when any of the status bits 0x40, 0x20, 0x10 or 0x08 is set and either receive command bit 0x10 or transmit command bit 0x08 is set. This does not depend on either route.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (reads have side effects only at 0x24) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| ev_rx_valid | input | 1 | Engine received a byte |
| ev_rx_byte | input | 8 | Received byte |
| ev_frame_err | input | 1 | Framing error event |
| ev_parity_err | input | 1 | Parity error event |
| ev_break | input | 1 | Break detected event |
| ev_tx_taken | input | 1 | Engine moved the holding byte into its shifter |
| ev_tx_done | input | 1 | Engine finished shifting |
| dsr_in | input | 1 | Data-set-ready line |
| cts_in | input | 1 | Clear-to-send line |
| cfg_ctrl | output | 8 | Control word to the engine |
| cfg_rx_cmd | output | 8 | Receive command word |
| cfg_tx_cmd | output | 8 | Transmit command word |
| cfg_divisor | output | 16 | Baud divisor |
| tx_data | output | 8 | Transmit holding byte |
| tx_load | output | 1 | One-cycle pulse after a data write |
| irq | output | 1 | Interrupt request |
| dma_req2 | output | 1 | DMA request, channel 2 |
| dma_req3 | output | 1 | DMA request, channel 3 |

## Verification
A corrupted status bit shows up right away on the request lines, because irq and the two DMA requests are computed combinationally from the status and command registers. The bench therefore sweeps every command value against several status patterns and compares all three request lines in the same cycle. A status bit updated with the wrong priority appears on the first read after the event. For this reason every event is followed by a read of the status address one cycle later, including the cases where a read and a new byte arrive together or where a byte arrives while data-ready is already set.

// File: rtl/uart_regfile.sv
module uart_regfile #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          ev_rx_valid,
  input  logic [7:0]    ev_rx_byte,
  input  logic          ev_frame_err,
  input  logic          ev_parity_err,
  input  logic          ev_break,
  input  logic          ev_tx_taken,
  input  logic          ev_tx_done,
  input  logic          dsr_in,
  input  logic          cts_in,
  output logic [7:0]    cfg_ctrl,
  output logic [7:0]    cfg_rx_cmd,
  output logic [7:0]    cfg_tx_cmd,
  output logic [15:0]   cfg_divisor,
  output logic [7:0]    tx_data,
  output logic          tx_load,
  output logic          irq,
  output logic          dma_req2,
  output logic          dma_req3
);
  localparam logic [3:0] W_LCLR = 4'h0, W_LSET = 4'h1, W_HCLR = 4'h2, W_HSET = 4'h3,
                         W_DIVH = 4'h4, W_DIVL = 4'h5, W_CTRL = 4'h6, W_RXC  = 4'h7,
                         W_TXC  = 4'h8, W_DATA = 4'h9;
  localparam logic [7:0] ERR_MASK = 8'h78;

  logic [3:0] word;
  logic [7:0] lsr, lsr_nxt, hs, hs_nxt, rx_byte;
  logic       dsr_q, cts_q;
  logic       wr_data, rd_data, rx_req, tx_req, err_req;

  assign word    = bus_addr[5:2];
  assign wr_data = bus_wr && word == W_DATA;
  assign rd_data = bus_rd && word == W_DATA;

  always_comb begin
    lsr_nxt = lsr;
    if (bus_wr && word == W_LCLR) lsr_nxt = lsr_nxt & ~bus_wdata;
    if (bus_wr && word == W_LSET) lsr_nxt = lsr_nxt | bus_wdata;
    if (rd_data) lsr_nxt[7] = 1'b0;
    if (ev_rx_valid) begin
      if (lsr[7] && !rd_data) lsr_nxt[5] = 1'b1;
      lsr_nxt[7] = 1'b1;
    end
    if (ev_frame_err)  lsr_nxt[6] = 1'b1;
    if (ev_parity_err) lsr_nxt[4] = 1'b1;
    if (ev_break)      lsr_nxt[3] = 1'b1;
    if (ev_tx_done)    lsr_nxt[1] = 1'b1;
    if (ev_tx_taken) begin
      lsr_nxt[2] = 1'b1;
      lsr_nxt[1] = 1'b0;
    end
    if (wr_data) lsr_nxt[2] = 1'b0;
    lsr_nxt[0] = 1'b0;
  end

  always_comb begin
    hs_nxt = hs;
    if (bus_wr && word == W_HCLR) hs_nxt = hs_nxt & ~bus_wdata;
    if (bus_wr && word == W_HSET) hs_nxt = hs_nxt | bus_wdata;
    if (dsr_in != dsr_q) hs_nxt[7] = 1'b1;
    if (cts_in != cts_q) hs_nxt[6] = 1'b1;
    hs_nxt[5:0] = 6'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lsr <= 8'h06;
      hs <= 8'h00;
      rx_byte <= 8'h00;
      dsr_q <= 1'b0;
      cts_q <= 1'b0;
      cfg_ctrl <= 8'h00;
      cfg_rx_cmd <= 8'h00;
      cfg_tx_cmd <= 8'h00;
      cfg_divisor <= 16'h0000;
      tx_data <= 8'h00;
      tx_load <= 1'b0;
    end else begin
      lsr <= lsr_nxt;
      hs <= hs_nxt;
      dsr_q <= dsr_in;
      cts_q <= cts_in;
      tx_load <= wr_data;
      if (ev_rx_valid) rx_byte <= ev_rx_byte;
      if (wr_data) tx_data <= bus_wdata;
      if (bus_wr) begin
        case (word)
          W_DIVH:  cfg_divisor[15:8] <= bus_wdata;
          W_DIVL:  cfg_divisor[7:0]  <= bus_wdata;
          W_CTRL:  cfg_ctrl   <= bus_wdata;
          W_RXC:   cfg_rx_cmd <= bus_wdata;
          W_TXC:   cfg_tx_cmd <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (word)
      W_LCLR, W_LSET: bus_rdata = lsr;
      W_HCLR, W_HSET: bus_rdata = hs;
      W_DIVH:  bus_rdata = cfg_divisor[15:8];
      W_DIVL:  bus_rdata = cfg_divisor[7:0];
      W_CTRL:  bus_rdata = cfg_ctrl;
      W_RXC:   bus_rdata = cfg_rx_cmd;
      W_TXC:   bus_rdata = cfg_tx_cmd;
      W_DATA:  bus_rdata = rx_byte;
      default: bus_rdata = 8'h00;
    endcase
  end

  assign rx_req  = cfg_rx_cmd[7] && lsr[7];
  assign tx_req  = cfg_tx_cmd[7] && cfg_tx_cmd[4] && lsr[2];
  assign err_req = (cfg_rx_cmd[4] || cfg_tx_cmd[3]) && |(lsr & ERR_MASK);

  assign irq      = (rx_req && cfg_rx_cmd[6:5] == 2'b01) ||
                    (tx_req && cfg_tx_cmd[6:5] == 2'b01) || err_req;
  assign dma_req2 = (rx_req && cfg_rx_cmd[6:5] == 2'b10) ||
                    (tx_req && cfg_tx_cmd[6:5] == 2'b10);
  assign dma_req3 = (rx_req && cfg_rx_cmd[6:5] == 2'b11) ||
                    (tx_req && cfg_tx_cmd[6:5] == 2'b11);
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] bus_addr,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic       ev_rx_valid,
  input logic       ev_tx_taken,
  input logic       tx_load,
  input logic [7:0] lsr
);
  logic data_rd, data_wr;
  assign data_rd = bus_rd && bus_addr[5:2] == 4'h9;
  assign data_wr = bus_wr && bus_addr[5:2] == 4'h9;

  AST_RX_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_valid |=> lsr[7]); // R4
  AST_READ_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !ev_rx_valid && !bus_wr) |=> !lsr[7]); // R4
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_valid && lsr[7] && !data_rd) |=> lsr[5]); // R5
  AST_DATA_WR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> (!lsr[2] && tx_load)); // R7
  AST_TAKEN_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_taken && !bus_wr) |=> (lsr[2] && !lsr[1])); // R7
endmodule

bind uart_regfile uart_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .ev_rx_valid(ev_rx_valid), .ev_tx_taken(ev_tx_taken), .tx_load(tx_load), .lsr(lsr)
);

// File: tb/uart_regfile_tb.sv
`timescale 1ns/1ps
module uart_regfile_tb;
  logic clk = 0, rst_n = 0;
  logic [5:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic ev_rx_valid = 0, ev_frame_err = 0, ev_parity_err = 0, ev_break = 0;
  logic ev_tx_taken = 0, ev_tx_done = 0, dsr_in = 0, cts_in = 0;
  logic [7:0] ev_rx_byte = 0;
  logic [7:0] cfg_ctrl, cfg_rx_cmd, cfg_tx_cmd, tx_data;
  logic [15:0] cfg_divisor;
  logic tx_load, irq, dma_req2, dma_req3;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_regfile u_dut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 0;
  endtask

  function automatic logic [2:0] exp_req(input logic [7:0] r, input logic [7:0] t, input logic [7:0] s);
    logic rr, tr, er;
    rr = r[7] & s[7];
    tr = t[7] & t[4] & s[2];
    er = (r[4] | t[3]) & (|(s & 8'h78));
    exp_req[2] = (rr & r[6:5] == 2'd1) | (tr & t[6:5] == 2'd1) | er;
    exp_req[1] = (rr & r[6:5] == 2'd2) | (tr & t[6:5] == 2'd2);
    exp_req[0] = (rr & r[6:5] == 2'd3) | (tr & t[6:5] == 2'd3);
  endfunction

  task automatic pulse(ref logic sig);
    sig = 1;
    @(negedge clk);
    sig = 0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] stat[4] = '{8'h80, 8'h04, 8'h20, 8'h00};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(6'h00, d); chk("R1 lsr", d, 8'h06);
    rd(6'h04, d); chk("R1 lsr alias", d, 8'h06);
    rd(6'h08, d); chk("R1 hs", d, 8'h00);
    rd(6'h18, d); chk("R1 ctrl", d, 8'h00);
    chk("R1 divisor", cfg_divisor, 16'h0);
    chk("R1 req", {irq, dma_req2, dma_req3}, 3'b000);

    // R2 readback sweep
    for (int v = 0; v < 256; v++) begin
      wr(6'h18, v[7:0]); wr(6'h1C, v[7:0] ^ 8'h3C); wr(6'h20, ~v[7:0]);
      wr(6'h10, v[7:0] ^ 8'hA5); wr(6'h14, v[7:0]);
      rd(6'h18, d); chk("R2 ctrl", {d, cfg_ctrl}, {v[7:0], v[7:0]});
      rd(6'h1C, d); chk("R2 rxcmd", {d, cfg_rx_cmd}, {2{v[7:0] ^ 8'h3C}});
      rd(6'h20, d); chk("R2 txcmd", {d, cfg_tx_cmd}, {2{~v[7:0]}});
      rd(6'h10, d); chk("R2 divh", d, v[7:0] ^ 8'hA5);
      chk("R2 divisor", cfg_divisor, {v[7:0] ^ 8'hA5, v[7:0]});
    end
    wr(6'h1C, 0); wr(6'h20, 0);

    // R3 set/clear sweeps
    for (int v = 0; v < 256; v++) begin
      logic [7:0] c;
      c = v[7:0] ^ 8'h5A;
      wr(6'h00, 8'hFF); wr(6'h04, v[7:0]);
      rd(6'h04, d); chk("R3 lsr set", d, v[7:0] & 8'hFE);
      wr(6'h00, c);
      rd(6'h00, d); chk("R3 lsr clr", d, v[7:0] & ~c & 8'hFE);
      wr(6'h08, 8'hFF); wr(6'h0C, v[7:0]);
      rd(6'h08, d); chk("R3 hs set", d, v[7:0] & 8'hC0);
      wr(6'h08, c);
      rd(6'h0C, d); chk("R3 hs clr", d, v[7:0] & ~c & 8'hC0);
    end
    // R3 event beats same-cycle clear
    wr(6'h00, 8'hFF);
    bus_addr = 6'h00; bus_wdata = 8'hFF; bus_wr = 1; ev_frame_err = 1;
    @(negedge clk); bus_wr = 0; ev_frame_err = 0;
    rd(6'h00, d); chk("R3 event priority", d, 8'h40);

    // R4 receive
    wr(6'h00, 8'hFF);
    ev_rx_byte = 8'hA5; pulse(ev_rx_valid);
    rd(6'h00, d); chk("R4 ready", d, 8'h80);
    rd(6'h24, d); chk("R4 byte", d, 8'hA5);
    rd(6'h00, d); chk("R4 cleared", d, 8'h00);
    ev_rx_byte = 8'h11; pulse(ev_rx_valid);
    bus_addr = 6'h24; bus_rd = 1; ev_rx_byte = 8'h22; ev_rx_valid = 1;
    #1 chk("R4 old byte", bus_rdata, 8'h11);
    @(negedge clk); bus_rd = 0; ev_rx_valid = 0;
    rd(6'h00, d); chk("R4 read+new keeps ready", d, 8'h80);
    rd(6'h24, d); chk("R4 new byte", d, 8'h22);

    // R5 overrun
    wr(6'h00, 8'hFF);
    ev_rx_byte = 8'h3C; pulse(ev_rx_valid);
    ev_rx_byte = 8'h5A; pulse(ev_rx_valid);
    rd(6'h00, d); chk("R5 overrun", d, 8'hA0);
    rd(6'h24, d); chk("R5 latest byte", d, 8'h5A);

    // R6 error events
    wr(6'h00, 8'hFF);
    pulse(ev_frame_err); rd(6'h00, d); chk("R6 frame", d, 8'h40);
    pulse(ev_parity_err); rd(6'h00, d); chk("R6 parity", d, 8'h50);
    pulse(ev_break); rd(6'h00, d); chk("R6 break", d, 8'h58);

    // R7 transmit
    wr(6'h00, 8'hFF); wr(6'h04, 8'h06);
    bus_addr = 6'h24; bus_wdata = 8'h77; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
    chk("R7 load pulse", {tx_load, tx_data}, {1'b1, 8'h77});
    @(negedge clk);
    chk("R7 load ends", tx_load, 1'b0);
    rd(6'h00, d); chk("R7 holding busy", d, 8'h02);
    pulse(ev_tx_taken); rd(6'h00, d); chk("R7 taken", d, 8'h04);
    pulse(ev_tx_done); rd(6'h00, d); chk("R7 done", d, 8'h06);

    // R8 handshake
    wr(6'h08, 8'hFF);
    dsr_in = 1; @(negedge clk);
    rd(6'h08, d); chk("R8 dsr change", d, 8'h80);
    cts_in = 1; @(negedge clk);
    rd(6'h08, d); chk("R8 cts change", d, 8'hC0);
    wr(6'h08, 8'h80); repeat (3) @(negedge clk);
    rd(6'h08, d); chk("R8 sticky", d, 8'h40);

    // R9 receive route sweep, R11 error path
    for (int r = 0; r < 256; r++)
      for (int k = 0; k < 4; k++) begin
        wr(6'h1C, r[7:0]); wr(6'h20, 0); wr(6'h00, 8'hFF); wr(6'h04, stat[k]);
        chk("R9/R11 rx route", {irq, dma_req2, dma_req3}, exp_req(r[7:0], 8'h00, stat[k]));
      end
    // R10 transmit route sweep, R11 error path
    for (int t = 0; t < 256; t++)
      for (int k = 0; k < 4; k++) begin
        wr(6'h1C, 0); wr(6'h20, t[7:0]); wr(6'h00, 8'hFF); wr(6'h04, stat[k]);
        chk("R10/R11 tx route", {irq, dma_req2, dma_req3}, exp_req(8'h00, t[7:0], stat[k]));
      end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule